// File: doc/BRIEF.md
# One-Dimensional Sub-Pixel Luma Interpolator

This block produces an 8x8 block of predicted luma pixels at a fractional sample position along one axis, either horizontal or vertical. Each output row is computed from one input row of eleven reference samples: the eight samples at the integer positions, one sample before them and two after them. Every output pixel is a 4-tap weighted sum of the samples at offsets -1, 0, +1 and +2 from its own position. The filter is chosen by a position code: quarter, half or three-quarter. A fourth code copies the integer sample unchanged.

The result is rounded and shifted, then clamped to 8 bits. A rounding-control bit biases the rounder. That bit is inverted when the block filters vertically. An averaging option merges each result with the pixel already at the destination, rounding up. The destination row travels alongside the reference row. The caller fetches the reference and destination rows and presents one row per accepted transfer. The block returns one output row per accepted row, one cycle later, and marks the eighth row of each block.

Top module: `subpel_interp`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `in_ready` are 0. From the first clock edge after reset is released, `in_ready` is 1.
- R2: A row accepted on a clock edge (`in_valid` and `in_ready` both high) appears on `out_pixels` with `out_valid` high after that edge. `out_valid` is low after any edge without an accepted row. Byte k of `in_samples` (bits 8k+7:8k) holds the sample at offset k-1 from output pixel 0. Byte j of `out_pixels` is output pixel j.
- R3: Position code 2 (half): pixel = (-s[-1] + 9*s[0] + 9*s[+1] - s[+2] + 8 - rc) >> 4, with an arithmetic shift. Here rc is the effective rounding control.
- R4: Position code 1 (quarter): pixel = (-4*s[-1] + 53*s[0] + 18*s[+1] - 3*s[+2] + 32 - rc) >> 6, with an arithmetic shift.
- R5: Position code 3 (three-quarter) uses the mirrored taps: pixel = (-3*s[-1] + 18*s[0] + 53*s[+1] - 4*s[+2] + 32 - rc) >> 6.
- R6: Every filtered value is clamped: below 0 gives 0, above 255 gives 255.
- R7: With `dir_vert` = 1 the effective rounding control is 1 - `rnd_ctl`. With `dir_vert` = 0 it is `rnd_ctl`.
- R8: With `avg_en` = 1 each output is (f + d + 1) >> 1, where f is the filtered pixel and d is the matching byte of `in_dst`. With `avg_en` = 0, `in_dst` has no effect on the output.
- R9: Position code 0 outputs s[0] for each pixel. The rounding control has no effect in this mode, and averaging still applies.
- R10: `out_last` is high with the 8th, 16th, ... output row counted from reset, and low with every other output row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input row present |
| in_ready | output | 1 | Block can accept a row |
| in_samples | input | 88 | Eleven reference samples, offset -1 in the low byte |
| in_dst | input | 64 | Existing destination row for averaging |
| mode | input | 2 | Position code: 0 copy, 1 quarter, 2 half, 3 three-quarter |
| rnd_ctl | input | 1 | Rounding-control bit |
| dir_vert | input | 1 | 1 when filtering vertically |
| avg_en | input | 1 | Average with the destination row |
| out_valid | output | 1 | Output row valid |
| out_pixels | output | 64 | Eight predicted pixels, pixel 0 in the low byte |
| out_last | output | 1 | Output row is the last row of a block |

## Verification
The assertions assume that every transfer holds a complete row. They also assume that the caller counts rows from reset in groups of eight, so the last-row marker can be checked against a simple output count. The bench sends only whole 8-row blocks and inserts idle gaps between transfers. It changes inputs only on the falling edge, so every accepted row is well defined. Sample values are random, plus hand-picked rows that drive the filter sums past both clamp limits and rows with uniform samples. These are combined with every mix of position code, direction, rounding bit and averaging.

// File: rtl/subpel_pkg.sv
// Shared types and constants for the sub-pixel interpolator.
// Assumes 8-bit samples and intermediate sums that fit in a signed 16-bit word.
package subpel_pkg;

    typedef enum logic [1:0] {
        SP_COPY    = 2'd0,
        SP_QUARTER = 2'd1,
        SP_HALF    = 2'd2,
        SP_THREEQ  = 2'd3
    } sp_mode_e;

    // Normalisation shifts for the two filter families
    localparam int SH_FINE = 6;
    localparam int SH_HALF = 4;

    // Rounder bases before the rounding control is subtracted
    localparam int RND_FINE = 32;
    localparam int RND_HALF = 8;

endpackage

// File: rtl/subpel_tap_lane.sv
// One output pixel of the 4-tap filter: weighted sum, rounding, shift, clamp.
// Assumes the four samples are unsigned and that ACC_W holds the worst-case
// sum (53+18)*max plus the rounder, which is signed 16 bits for 8-bit pixels.
module subpel_tap_lane
    import subpel_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int ACC_W = 16
) (
    input  logic [PIX_W-1:0] s_m1,
    input  logic [PIX_W-1:0] s_0,
    input  logic [PIX_W-1:0] s_p1,
    input  logic [PIX_W-1:0] s_p2,
    input  sp_mode_e         mode,
    input  logic             rc,
    output logic [PIX_W-1:0] pix
);
    localparam int PAD = ACC_W - PIX_W;
    localparam logic signed [ACC_W-1:0] K3      = ACC_W'(3);
    localparam logic signed [ACC_W-1:0] K9      = ACC_W'(9);
    localparam logic signed [ACC_W-1:0] K18     = ACC_W'(18);
    localparam logic signed [ACC_W-1:0] K53     = ACC_W'(53);
    localparam logic signed [ACC_W-1:0] KR_FINE = ACC_W'(RND_FINE);
    localparam logic signed [ACC_W-1:0] KR_HALF = ACC_W'(RND_HALF);
    localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'((1 << PIX_W) - 1);

    logic signed [ACC_W-1:0] xa, xb, xc, xd, rcx;
    logic signed [ACC_W-1:0] acc, shifted;

    assign xa  = $signed({{PAD{1'b0}}, s_m1});
    assign xb  = $signed({{PAD{1'b0}}, s_0});
    assign xc  = $signed({{PAD{1'b0}}, s_p1});
    assign xd  = $signed({{PAD{1'b0}}, s_p2});
    assign rcx = $signed({{(ACC_W-1){1'b0}}, rc});

    // Weighted sum with rounder, then the family-specific arithmetic shift
    always_comb begin
        case (mode)
            SP_QUARTER: begin
                acc     = xb * K53 + xc * K18 - (xa <<< 2) - xd * K3 + KR_FINE - rcx;
                shifted = acc >>> SH_FINE;
            end
            SP_THREEQ: begin
                acc     = xb * K18 + xc * K53 - xa * K3 - (xd <<< 2) + KR_FINE - rcx;
                shifted = acc >>> SH_FINE;
            end
            SP_HALF: begin
                acc     = (xb + xc) * K9 - xa - xd + KR_HALF - rcx;
                shifted = acc >>> SH_HALF;
            end
            default: begin
                acc     = xb;
                shifted = xb;
            end
        endcase
    end

    // Saturate to the unsigned pixel range
    always_comb begin
        if (shifted < 0)
            pix = '0;
        else if (shifted > PIX_MAX)
            pix = '1;
        else
            pix = shifted[PIX_W-1:0];
    end

endmodule

// File: rtl/subpel_avg_lane.sv
// Optional merge of a filtered pixel with the destination pixel, rounding up.
// Assumes both operands are unsigned pixels of the same width.
module subpel_avg_lane #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] fresh,
    input  logic [PIX_W-1:0] prior,
    input  logic             en,
    output logic [PIX_W-1:0] pix
);
    logic [PIX_W:0] sum;

    // Round-up mean, or pass the filtered value through
    always_comb begin
        sum = {1'b0, fresh} + {1'b0, prior} + {{PIX_W{1'b0}}, 1'b1};
        pix = en ? sum[PIX_W:1] : fresh;
    end

endmodule

// File: rtl/subpel_interp.sv
// Row-streaming 1-D sub-pixel interpolator. For each accepted row of
// ROW_PIX+3 samples it filters ROW_PIX pixels in parallel and registers them,
// so results appear one cycle after acceptance. It marks every ROWS-th row.
// Assumes the caller sends whole blocks of ROWS rows after reset.
module subpel_interp
    import subpel_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int ROW_PIX = 8,
    parameter int ROWS    = 8,
    parameter int ACC_W   = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [(ROW_PIX+3)*PIX_W-1:0]  in_samples,
    input  logic [ROW_PIX*PIX_W-1:0]      in_dst,
    input  logic [1:0]                    mode,
    input  logic                          rnd_ctl,
    input  logic                          dir_vert,
    input  logic                          avg_en,
    output logic                          out_valid,
    output logic [ROW_PIX*PIX_W-1:0]      out_pixels,
    output logic                          out_last
);
    localparam int CNT_W = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ROWS - 1);

    logic                     accept;
    logic                     rc_eff;
    sp_mode_e                 mode_e;
    logic [ROW_PIX*PIX_W-1:0] row_next;
    logic [CNT_W-1:0]         row_idx;

    assign accept = in_valid && in_ready;
    assign rc_eff = dir_vert ? ~rnd_ctl : rnd_ctl;
    assign mode_e = sp_mode_e'(mode);

    // One filter and one averaging lane per output pixel
    for (genvar j = 0; j < ROW_PIX; j++) begin : g_lane
        logic [PIX_W-1:0] filt;

        subpel_tap_lane #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_tap (
            .s_m1 (in_samples[PIX_W*(j+0) +: PIX_W]),
            .s_0  (in_samples[PIX_W*(j+1) +: PIX_W]),
            .s_p1 (in_samples[PIX_W*(j+2) +: PIX_W]),
            .s_p2 (in_samples[PIX_W*(j+3) +: PIX_W]),
            .mode (mode_e),
            .rc   (rc_eff),
            .pix  (filt)
        );

        subpel_avg_lane #(.PIX_W(PIX_W)) u_avg (
            .fresh (filt),
            .prior (in_dst[PIX_W*j +: PIX_W]),
            .en    (avg_en),
            .pix   (row_next[PIX_W*j +: PIX_W])
        );
    end

    // Ready comes up on the first edge after reset and stays up
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_ready <= 1'b0;
        else
            in_ready <= 1'b1;
    end

    // Output row register with valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_pixels <= '0;
        end else begin
            out_valid <= accept;
            if (accept)
                out_pixels <= row_next;
        end
    end

    // Row position within the block and the last-row marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_idx  <= '0;
            out_last <= 1'b0;
        end else if (accept) begin
            out_last <= (row_idx == LAST_IDX);
            row_idx  <= (row_idx == LAST_IDX) ? '0 : row_idx + 1'b1;
        end else begin
            out_last <= 1'b0;
        end
    end

endmodule

// File: rtl/subpel_interp_chk.sv
// Protocol checks for subpel_interp, attached by bind. Keeps its own count
// of emitted rows to check the last-row marker independently.
module subpel_interp_chk #(
    parameter int PIX_W   = 8,
    parameter int ROW_PIX = 8,
    parameter int ROWS    = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         in_valid,
    input logic                         in_ready,
    input logic [ROW_PIX*PIX_W-1:0]     out_pixels,
    input logic                         out_valid,
    input logic                         out_last
);
    localparam int CNT_W = (ROWS > 1) ? $clog2(ROWS) : 1;

    logic [CNT_W-1:0] seen;

    // Count emitted rows modulo the block height
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen <= '0;
        else if (out_valid)
            seen <= (seen == CNT_W'(ROWS - 1)) ? '0 : seen + 1'b1;
    end

    // R1
    ready_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> in_ready);

    // R2
    accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R2
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !out_valid);

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(out_pixels));

    // R10
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R10
    last_on_block_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen == CNT_W'(ROWS - 1)) |-> out_last);

    // R10
    no_early_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen != CNT_W'(ROWS - 1)) |-> !out_last);

endmodule

bind subpel_interp subpel_interp_chk #(
    .PIX_W   (PIX_W),
    .ROW_PIX (ROW_PIX),
    .ROWS    (ROWS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_pixels (out_pixels),
    .out_valid  (out_valid),
    .out_last   (out_last)
);

// File: tb/subpel_interp_tb.sv
// Self-checking bench: a behavioural integer model predicts each output row
// from the inputs present at the accepting edge; outputs are compared every cycle.
module subpel_interp_tb;
    localparam int NS = 11;
    localparam int NP = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [NS*8-1:0] in_samples = '0;
    logic [NP*8-1:0] in_dst = '0;
    logic [1:0]      mode = 2'd0;
    logic            rnd_ctl = 1'b0;
    logic            dir_vert = 1'b0;
    logic            avg_en = 1'b0;
    logic            out_valid;
    logic [NP*8-1:0] out_pixels;
    logic            out_last;

    int n_checks = 0;
    int n_fail = 0;
    int rows_seen = 0;
    logic rdy_seen = 1'b0;

    always #4 clk = ~clk;

    subpel_interp u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_samples(in_samples), .in_dst(in_dst), .mode(mode), .rnd_ctl(rnd_ctl),
        .dir_vert(dir_vert), .avg_en(avg_en), .out_valid(out_valid),
        .out_pixels(out_pixels), .out_last(out_last)
    );

    // Behavioural reference for one output row
    function automatic logic [NP*8-1:0] ref_row(logic [NS*8-1:0] s, logic [NP*8-1:0] d,
                                                int md, bit rb, bit vt, bit av);
        logic [NP*8-1:0] r;
        int rc;
        rc = vt ? 1 - rb : rb;
        for (int j = 0; j < NP; j++) begin
            int a, b, c, e, v;
            a = s[8*j +: 8]; b = s[8*(j+1) +: 8]; c = s[8*(j+2) +: 8]; e = s[8*(j+3) +: 8];
            case (md)
                1: v = (-4*a + 53*b + 18*c - 3*e + 32 - rc) >>> 6;
                2: v = (-a + 9*b + 9*c - e + 8 - rc) >>> 4;
                3: v = (-3*a + 18*b + 53*c - 4*e + 32 - rc) >>> 6;
                default: v = b;
            endcase
            if (v < 0) v = 0;
            if (v > 255) v = 255;
            if (av) v = (v + int'(d[8*j +: 8]) + 1) >> 1;
            r[8*j +: 8] = 8'(v);
        end
        return r;
    endfunction

    function automatic string tag_of(int md, bit vt, bit av);
        string t;
        case (md)
            1: t = "R4";
            2: t = "R3";
            3: t = "R5";
            default: t = "R9";
        endcase
        if (vt) t = {t, "/R7"};
        if (av) t = {t, "/R8"};
        else t = {t, "/R8(dst ignored)"};
        return {t, "/R6"};
    endfunction

    task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Remember ready as seen away from the edge
    always @(negedge clk) rdy_seen <= in_ready;

    // Cycle monitor: predict at the edge, compare just after it
    always @(posedge clk) begin
        bit acc;
        logic [NP*8-1:0] exp_row;
        bit exp_last;
        acc = rst_n && in_valid && rdy_seen;
        exp_row = ref_row(in_samples, in_dst, int'(mode), rnd_ctl, dir_vert, avg_en);
        exp_last = acc && ((rows_seen % 8) == 7);
        if (acc) rows_seen++;
        #2;
        if (!rst_n) begin
            check(!out_valid && !in_ready, "R1", {out_valid, in_ready}, 2'b00);
        end else begin
            check(out_valid == acc, "R2", out_valid, acc);
            if (acc) begin
                check(out_pixels == exp_row, tag_of(int'(mode), dir_vert, avg_en),
                      out_pixels, exp_row);
                check(out_last == exp_last, "R10", out_last, exp_last);
            end
        end
    end

    task automatic send_row(logic [NS*8-1:0] s, logic [NP*8-1:0] d,
                            int md, bit rb, bit vt, bit av, bit gap);
        @(negedge clk);
        in_valid = 1'b1; in_samples = s; in_dst = d;
        mode = 2'(md); rnd_ctl = rb; dir_vert = vt; avg_en = av;
        if (gap) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_samples = ~s;
        end
    endtask

    function automatic logic [NS*8-1:0] rand_samples();
        logic [NS*8-1:0] s;
        for (int k = 0; k < NS; k++) s[8*k +: 8] = 8'($urandom_range(0, 255));
        return s;
    endfunction

    function automatic logic [NS*8-1:0] pat(int lo, int hi, int phase);
        logic [NS*8-1:0] s;
        for (int k = 0; k < NS; k++) s[8*k +: 8] = (((k + phase) % 4) < 2) ? 8'(lo) : 8'(hi);
        return s;
    endfunction

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", in_ready, 1'b1);
        // All mode/direction/rounding/averaging combinations, random data
        for (int md = 0; md < 4; md++)
            for (int vt = 0; vt < 2; vt++)
                for (int rb = 0; rb < 2; rb++)
                    for (int av = 0; av < 2; av++)
                        for (int r = 0; r < 8; r++)
                            send_row(rand_samples(), {$urandom, $urandom}, md, bit'(rb),
                                     bit'(vt), bit'(av), (r % 3) == 1);
        // Clamp corners (R6): high and low saturation in every filter mode
        for (int md = 1; md < 4; md++)
            for (int r = 0; r < 8; r++)
                send_row(r[0] ? pat(255, 0, r) : pat(0, 255, r), '0, md,
                         bit'(r >> 1), bit'(r >> 2), 1'b0, 1'b0);
        // Uniform rows and extreme destination averaging
        for (int r = 0; r < 8; r++)
            send_row({NS{8'(r * 36)}}, {NP{8'hFF}}, (r % 3) + 1, bit'(r), 1'b0, bit'(r >> 2), 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule